// File: doc/BRIEF.md
# Universal Latched/Registered Bus Transceiver

This block is a bidirectional data path between an A port and a B port, one channel per bit, 18 channels by default. Each direction (A to B, B to A) has its own storage stage, which is either a transparent latch or a register loaded on the falling edge of that direction's strobe. A high latch enable selects transparent mode. A low latch enable selects registered mode. Each direction also has its own output enable. The enable that gates the B pads is active high, and the enable that gates the A pads is active low.

The pads are split into a data-in, a data-out and a per-bit drive-enable, so that a tristate buffer can be placed at the chip boundary. The direction strobes are not used as clocks. They are sampled by a faster system clock, and a falling edge is a high sample followed by a low sample. Each data input has a keeper. While the outside world does not drive an input bit, the path sees the level that bit last held while it was driven.

Top module: `ubt_transceiver`

## Requirements
- R1: While `ab_le` is 1, `b_o` equals the keeper-resolved A input in the same cycle, with no clock edge in between.
- R2: While `ab_le` is 0, a system-clock edge at which `ab_clk` is sampled 0, after being 1 at the previous edge, loads the A value into the A-to-B store. `b_o` shows that value from that edge on.
- R3: While `ab_le` is 0 and `ab_clk` stays high, stays low or rises, the store keeps its value, whatever A does.
- R4: When `ab_le` goes from 1 to 0 with `ab_clk` low, `b_o` holds the A value that was sampled at the last system-clock edge while `ab_le` was 1.
- R5: `b_en` is all ones when `ab_oe` is 1. It is all zeros when `ab_oe` is 0, whatever the latch enable, strobe and data are.
- R6: The B-to-A path behaves like the A-to-B path, using `ba_le` and `ba_clk`. Its enable `ba_oe_n` is active low, so `a_en` is all ones when it is 0 and all zeros when it is 1.
- R7: While bit i of `a_ext_drv` (or `b_ext_drv`) is 0, that bit's input level is ignored. The path uses the level the bit had at the last system-clock edge at which it was driven. Bits with the driven flag at 1 pass straight through.
- R8: A synchronous active-high `rst` clears both stores, both keepers and the strobe history to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes and updates the stores |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | W | Level seen at the A pads |
| a_ext_drv | input | W | Per bit: 1 when an outside driver is driving that A pad |
| a_o | output | W | Data to the A pads (B-to-A path) |
| a_en | output | W | Per-bit drive enable for the A pads |
| b_i | input | W | Level seen at the B pads |
| b_ext_drv | input | W | Per bit: 1 when an outside driver is driving that B pad |
| b_o | output | W | Data to the B pads (A-to-B path) |
| b_en | output | W | Per-bit drive enable for the B pads |
| ab_le | input | 1 | A-to-B latch enable; 1 selects transparent mode |
| ab_clk | input | 1 | A-to-B strobe; its falling edge loads the store |
| ab_oe | input | 1 | B pad enable, active high |
| ba_le | input | 1 | B-to-A latch enable; 1 selects transparent mode |
| ba_clk | input | 1 | B-to-A strobe; its falling edge loads the store |
| ba_oe_n | input | 1 | A pad enable, active low |

## Verification
The bench builds the transceiver with W = 4. With four bits, every one of the 16 data words goes through transparent mode in both directions and through falling-edge capture. At that width, one keeper test with a mixed driven mask covers bits that pass through and bits that hold at the same time. The strobe sequences cover a rising edge, a steady high level, a steady low level and a latch enable that drops while data is changing.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  localparam int unsigned CHANNELS = 18;

  typedef struct packed {
    logic latch_en;
    logic strobe;
    logic drive_on;
  } xfer_ctl_t;

endpackage

// File: rtl/ubt_bus_keeper.sv
module ubt_bus_keeper #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] driven,
  output logic [W-1:0] level
);

  logic [W-1:0] kept;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            kept[i] <= 1'b0;
      else if (driven[i]) kept[i] <= pin[i];
    end

    assign level[i] = driven[i] ? pin[i] : kept[i];

    // R7: an undriven bit keeps its remembered level
    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
      !driven[i] |=> kept[i] == $past(kept[i]));
  end

endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path
  import ubt_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  xfer_ctl_t    ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_en
);

  logic         strobe_q;
  logic         fall;
  logic [W-1:0] store;

  assign fall = strobe_q & ~ctl.strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      store    <= '0;
    end else begin
      strobe_q <= ctl.strobe;
      if (ctl.latch_en || fall) store <= d;
    end
  end

  assign q    = ctl.latch_en ? d : store;
  assign q_en = {W{ctl.drive_on}};

  // R2: falling strobe in registered mode loads the input
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.latch_en && fall) |=> store == $past(d));

  // R3: no falling strobe in registered mode keeps the store
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl.latch_en && !fall) |=> store == $past(store));

  // R4: transparent mode tracks the input so the last value is held
  p_track_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.latch_en |=> store == $past(d));

endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
  import ubt_pkg::*;
#(
  parameter int unsigned W = CHANNELS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] a_ext_drv,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_en,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] b_ext_drv,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_en,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n
);

  logic [W-1:0] a_seen;
  logic [W-1:0] b_seen;
  xfer_ctl_t    ab_ctl;
  xfer_ctl_t    ba_ctl;

  assign ab_ctl = '{latch_en: ab_le, strobe: ab_clk, drive_on: ab_oe};
  assign ba_ctl = '{latch_en: ba_le, strobe: ba_clk, drive_on: ~ba_oe_n};

  ubt_bus_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst(rst), .pin(a_i), .driven(a_ext_drv), .level(a_seen)
  );

  ubt_bus_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst(rst), .pin(b_i), .driven(b_ext_drv), .level(b_seen)
  );

  ubt_dir_path #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .ctl(ab_ctl), .d(a_seen), .q(b_o), .q_en(b_en)
  );

  ubt_dir_path #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .ctl(ba_ctl), .d(b_seen), .q(a_o), .q_en(a_en)
  );

  // R1: fully driven A passes straight to B in transparent mode
  p_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (ab_le && (&a_ext_drv)) |-> b_o == a_i);

  // R5: B pads released whenever the active-high enable is low
  p_b_off_r5: assert property (@(posedge clk) disable iff (rst)
    !ab_oe |-> b_en == '0);

  // R6: A pads follow the active-low enable
  p_a_off_r6: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |-> a_en == '0);
  p_a_on_r6: assert property (@(posedge clk) disable iff (rst)
    !ba_oe_n |-> &a_en);

endmodule

// File: tb/sim_ubt_transceiver.sv
module sim_ubt_transceiver;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_i, a_ext_drv, a_o, a_en;
  logic [W-1:0] b_i, b_ext_drv, b_o, b_en;
  logic         ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;
  logic [W-1:0] held;

  always #5 clk = ~clk;

  ubt_transceiver #(.W(W)) u0 (
    .clk(clk), .rst(rst),
    .a_i(a_i), .a_ext_drv(a_ext_drv), .a_o(a_o), .a_en(a_en),
    .b_i(b_i), .b_ext_drv(b_ext_drv), .b_o(b_o), .b_en(b_en),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    rst = 1'b1;
    a_i = '0; b_i = '0; a_ext_drv = '0; b_ext_drv = '0;
    ab_le = 1'b0; ab_clk = 1'b0; ab_oe = 1'b0;
    ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R8 / R5 / R6: reset state and pad enables released
    chk("R5 b_en off after reset", b_en, '0);
    chk("R6 a_en off after reset", a_en, '0);
    ab_oe = 1'b1; ba_oe_n = 1'b0; #1;
    chk("R8 b_o cleared", b_o, '0);
    chk("R8 a_o cleared", a_o, '0);
    chk("R5 b_en on", b_en, '1);
    chk("R6 a_en on", a_en, '1);

    // R7: keeper resets to zero, undriven input ignored
    ab_le = 1'b1; a_i = '1; #1;
    chk("R7 undriven A reads keeper zero", b_o, '0);

    // R1: transparent sweep, A to B
    a_ext_drv = '1;
    for (int v = 0; v < 16; v++) begin
      a_i = v[W-1:0]; #1;
      chk("R1 transparent", b_o, v[W-1:0]);
      tick();
    end

    // R4: latch enable falls with strobe low
    a_i = 4'h9; tick();
    ab_le = 1'b0; a_i = 4'h6; #1;
    chk("R4 held after le fall", b_o, 4'h9);
    tick();
    chk("R4 held next cycle", b_o, 4'h9);
    held = 4'h9;

    // R2 / R3: falling edge capture sweep, rising edge ignored
    for (int v = 0; v < 16; v++) begin
      a_i = v[W-1:0] ^ 4'hA; ab_clk = 1'b1; tick();
      chk("R3 rising strobe no load", b_o, held);
      ab_clk = 1'b0; tick();
      chk("R2 falling strobe load", b_o, v[W-1:0] ^ 4'hA);
      held = v[W-1:0] ^ 4'hA;
    end

    // R3: steady high, then steady low
    ab_clk = 1'b1; tick();
    for (int k = 0; k < 4; k++) begin
      a_i = k[W-1:0] ^ 4'h5; tick();
      chk("R3 steady high hold", b_o, held);
    end
    ab_clk = 1'b0; tick();
    chk("R2 load after steady high", b_o, 4'h6);
    held = 4'h6;
    for (int k = 0; k < 4; k++) begin
      a_i = ~k[W-1:0]; tick();
      chk("R3 steady low hold", b_o, held);
    end

    // R5: disabled regardless of le, strobe, data
    ab_oe = 1'b0;
    for (int k = 0; k < 8; k++) begin
      ab_le = k[0]; ab_clk = k[1]; a_i = k[W-1:0] * 3; tick();
      chk("R5 b_en off under activity", b_en, '0);
    end
    ab_oe = 1'b1; #1;
    chk("R5 b_en back on", b_en, '1);

    // R6: B to A transparent and capture, active-low enable
    b_ext_drv = '1; ba_le = 1'b1;
    for (int v = 0; v < 16; v++) begin
      b_i = v[W-1:0]; #1;
      chk("R6 B to A transparent", a_o, v[W-1:0]);
      tick();
    end
    ba_le = 1'b0; b_i = 4'h3; tick();
    chk("R6 B to A held", a_o, 4'hF);
    ba_clk = 1'b1; tick();
    chk("R6 B to A rising ignored", a_o, 4'hF);
    ba_clk = 1'b0; tick();
    chk("R6 B to A falling load", a_o, 4'h3);
    ba_oe_n = 1'b1; #1;
    chk("R6 a_en off", a_en, '0);

    // R7: per-bit keeper with a mixed driven mask
    ab_le = 1'b1; a_ext_drv = '1; a_i = 4'h5; tick();
    a_ext_drv = 4'b0011; a_i = 4'b1010; #1;
    chk("R7 mixed mask", b_o, 4'b0110);
    tick();
    a_i = 4'b0000; #1;
    chk("R7 mixed mask second", b_o, 4'b0100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule